// File: doc/BRIEF.md
# Transaction ID Match Filter for Bus Event Counters

This block watches the read-address and write-address channels of an AXI port and decides, for each of a small set of event counters, whether an accepted burst belongs to that counter. A burst counts when the counter's event code selects its channel, its transaction ID agrees with a programmed ID under a programmed mask, and, in per-counter mode, its port number agrees with a programmed port. Each counter gets a one-cycle strobe and an increment value. The increment is either one per burst or the number of bytes the burst moves.

Configuration arrives through a simple write port. There is one shared compare register, used by every counter in shared mode. There is also a compare register and a port select register for each counter, used in per-counter mode. The mask half of each compare register holds the inverse of the mask. A register that resets to zero therefore matches only ID 0 exactly. The counters themselves sit outside this block and add `incr_o` when `match_o` is high.

Top module: `axi_id_filter`

## Requirements
- R1: After reset, `match_o` and `incr_o` are zero, and every configuration register is zero.
- R2: A compare register holds the ID in bits [15:0] and the stored mask in bits [31:16]. The effective mask is the inverse of the stored mask. An ID matches when `((id ^ cmp_id) & effective_mask) == 0`.
- R3: Event code 0x41 selects the read-address channel and 0x42 selects the write-address channel. Any other code never raises that counter's strobe.
- R4: A burst is considered only on a handshake (valid and ready both high). The strobe appears in the cycle after the handshake, and there is one strobe per accepted burst.
- R5: With `per_cnt_i` low, the shared compare register at address 0x30 applies to every counter, and port numbers are ignored.
- R6: With `per_cnt_i` high, counter k (k = 1..NCNT) uses the compare register at address 0x54 + 16·(k−1) and the select register at address 0x50 + 16·(k−1).
- R7: In the select register, bits [2:0] hold the read port and bit 3 is the read port-check bit. Bits [10:8] hold the write port and bit 11 is the write port-check bit. A check bit of 0 requires the port to be equal; a check bit of 1 accepts any port.
- R8: With `byte_mode_i` low, a strobe carries an increment of 1. With it high, the increment is (len+1)·2^size of the matching burst.
- R9: A write to any address other than the configuration addresses changes no register.
- R10: `incr_o` of a counter is zero whenever its strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | ADDR_W | Configuration byte address |
| cfg_wdata_i | input | 2·ID_W | Configuration write data |
| per_cnt_i | input | 1 | 1: per-counter compare and port check; 0: shared compare |
| byte_mode_i | input | 1 | 1: byte increments; 0: one per burst |
| evt_sel_i | input | NCNT·8 | Event code of each counter, counter 1 in the low byte |
| ar_valid_i | input | 1 | Read address valid |
| ar_ready_i | input | 1 | Read address ready |
| ar_id_i | input | ID_W | Read transaction ID |
| ar_port_i | input | 3 | Read port number |
| ar_len_i | input | LEN_W | Read burst length minus one |
| ar_size_i | input | SIZE_W | Read beat size, log2 bytes |
| aw_valid_i | input | 1 | Write address valid |
| aw_ready_i | input | 1 | Write address ready |
| aw_id_i | input | ID_W | Write transaction ID |
| aw_port_i | input | 3 | Write port number |
| aw_len_i | input | LEN_W | Write burst length minus one |
| aw_size_i | input | SIZE_W | Write beat size, log2 bytes |
| match_o | output | NCNT | Per-counter match strobe |
| incr_o | output | NCNT·INC_W | Per-counter increment, counter 1 in the low slice |

## Verification
The assertions check, on every cycle, the properties that hold whatever is programmed. A strobe never follows a cycle with no handshake. A strobe never comes from a counter whose event code is neither read nor write match. An increment is zero without a strobe, never zero with one, and equal to one in count mode. Whether the mask inversion, the register addresses, the port-check bits and the byte arithmetic are right depends on the programmed values. The bench shows these through sweeps over IDs, ports, lengths and sizes in all four mode combinations. Each result is compared with an arithmetic model, and the sweeps also include writes to unused addresses.

// File: rtl/afl_pkg.sv
package afl_pkg;
  localparam int EVT_W = 8;
  localparam logic [EVT_W-1:0] EVT_RD_MATCH = 8'h41;
  localparam logic [EVT_W-1:0] EVT_WR_MATCH = 8'h42;

  localparam int ADR_SHARED = 'h30;
  localparam int ADR_SEL_BASE = 'h50;
  localparam int ADR_CMP_BASE = 'h54;
  localparam int ADR_STRIDE = 'h10;

  localparam int PORT_W = 3;
  localparam int RD_PORT_LSB = 0;
  localparam int RD_CHK_BIT = 3;
  localparam int WR_PORT_LSB = 8;
  localparam int WR_CHK_BIT = 11;
  localparam int SEL_W = 12;

  typedef enum logic [1:0] {CH_NONE, CH_RD, CH_WR} chan_e;

  function automatic chan_e evt_chan(input logic [EVT_W-1:0] code);
    if (code == EVT_RD_MATCH) return CH_RD;
    if (code == EVT_WR_MATCH) return CH_WR;
    return CH_NONE;
  endfunction
endpackage

// File: rtl/afl_id_match.sv
module afl_id_match #(
  parameter int ID_W = 16
) (
  input  logic [ID_W-1:0]   id_i,
  input  logic [2*ID_W-1:0] cmp_i,
  output logic              hit_o
);
  // upper half holds the mask inverted: 0 = compare this bit
  assign hit_o = ((id_i ^ cmp_i[ID_W-1:0]) & ~cmp_i[2*ID_W-1:ID_W]) == '0;
endmodule

// File: rtl/afl_cfg_regs.sv
module afl_cfg_regs
  import afl_pkg::*;
#(
  parameter int NCNT   = 3,
  parameter int ADDR_W = 8,
  parameter int REG_W  = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [REG_W-1:0]     wdata_i,
  output logic [REG_W-1:0]     shared_o,
  output logic [NCNT*REG_W-1:0] cmp_o,
  output logic [NCNT*SEL_W-1:0] sel_o
);
  localparam logic [ADDR_W-1:0] A_SHARED = ADDR_W'(ADR_SHARED);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) shared_o <= '0;
    else if (we_i && addr_i == A_SHARED) shared_o <= wdata_i;
  end

  for (genvar k = 0; k < NCNT; k++) begin : g_reg
    localparam logic [ADDR_W-1:0] A_CMP = ADDR_W'(ADR_CMP_BASE + k * ADR_STRIDE);
    localparam logic [ADDR_W-1:0] A_SEL = ADDR_W'(ADR_SEL_BASE + k * ADR_STRIDE);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cmp_o[k*REG_W +: REG_W] <= '0;
        sel_o[k*SEL_W +: SEL_W] <= '0;
      end else if (we_i) begin
        if (addr_i == A_CMP) cmp_o[k*REG_W +: REG_W] <= wdata_i;
        if (addr_i == A_SEL) sel_o[k*SEL_W +: SEL_W] <= wdata_i[SEL_W-1:0];
      end
    end
  end
endmodule

// File: rtl/afl_burst_bytes.sv
module afl_burst_bytes #(
  parameter int LEN_W  = 8,
  parameter int SIZE_W = 3,
  parameter int INC_W  = LEN_W + 1 + (2**SIZE_W - 1)
) (
  input  logic [LEN_W-1:0]  len_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic [INC_W-1:0]  bytes_o
);
  logic [LEN_W:0] beats;
  assign beats   = {1'b0, len_i} + (LEN_W+1)'(1);
  assign bytes_o = INC_W'(beats) << size_i;
endmodule

// File: rtl/afl_lane.sv
module afl_lane
  import afl_pkg::*;
#(
  parameter int ID_W  = 16,
  parameter int INC_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [EVT_W-1:0]   evt_i,
  input  logic [2*ID_W-1:0]  cmp_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic               per_cnt_i,
  input  logic               byte_mode_i,
  input  logic               rd_hs_i,
  input  logic [ID_W-1:0]    rd_id_i,
  input  logic [PORT_W-1:0]  rd_port_i,
  input  logic [INC_W-1:0]   rd_bytes_i,
  input  logic               wr_hs_i,
  input  logic [ID_W-1:0]    wr_id_i,
  input  logic [PORT_W-1:0]  wr_port_i,
  input  logic [INC_W-1:0]   wr_bytes_i,
  output logic               match_o,
  output logic [INC_W-1:0]   incr_o
);
  chan_e             chan;
  logic              use_wr;
  logic              hs, port_ok, id_hit, hit;
  logic [ID_W-1:0]   id_sel;
  logic [INC_W-1:0]  bytes_sel, incr_d;

  assign chan   = evt_chan(evt_i);
  assign use_wr = (chan == CH_WR);
  assign id_sel = use_wr ? wr_id_i : rd_id_i;

  afl_id_match #(.ID_W(ID_W)) u_cmp (
    .id_i  (id_sel),
    .cmp_i (cmp_i),
    .hit_o (id_hit)
  );

  always_comb begin
    hs        = 1'b0;
    port_ok   = 1'b1;
    bytes_sel = rd_bytes_i;
    unique case (chan)
      CH_RD: begin
        hs      = rd_hs_i;
        port_ok = !per_cnt_i || sel_i[RD_CHK_BIT]
                  || rd_port_i == sel_i[RD_PORT_LSB +: PORT_W];
      end
      CH_WR: begin
        hs        = wr_hs_i;
        bytes_sel = wr_bytes_i;
        port_ok   = !per_cnt_i || sel_i[WR_CHK_BIT]
                    || wr_port_i == sel_i[WR_PORT_LSB +: PORT_W];
      end
      default: hs = 1'b0;
    endcase
    hit    = hs && id_hit && port_ok;
    incr_d = !hit ? '0 : (byte_mode_i ? bytes_sel : INC_W'(1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_o <= 1'b0;
      incr_o  <= '0;
    end else begin
      match_o <= hit;
      incr_o  <= incr_d;
    end
  end
endmodule

// File: rtl/axi_id_filter.sv
module axi_id_filter
  import afl_pkg::*;
#(
  parameter int NCNT   = 3,
  parameter int ID_W   = 16,
  parameter int LEN_W  = 8,
  parameter int SIZE_W = 3,
  parameter int ADDR_W = 8,
  localparam int REG_W = 2 * ID_W,
  localparam int INC_W = LEN_W + 1 + (2**SIZE_W - 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cfg_we_i,
  input  logic [ADDR_W-1:0]       cfg_addr_i,
  input  logic [REG_W-1:0]        cfg_wdata_i,
  input  logic                    per_cnt_i,
  input  logic                    byte_mode_i,
  input  logic [NCNT*EVT_W-1:0]   evt_sel_i,
  input  logic                    ar_valid_i,
  input  logic                    ar_ready_i,
  input  logic [ID_W-1:0]         ar_id_i,
  input  logic [PORT_W-1:0]       ar_port_i,
  input  logic [LEN_W-1:0]        ar_len_i,
  input  logic [SIZE_W-1:0]       ar_size_i,
  input  logic                    aw_valid_i,
  input  logic                    aw_ready_i,
  input  logic [ID_W-1:0]         aw_id_i,
  input  logic [PORT_W-1:0]       aw_port_i,
  input  logic [LEN_W-1:0]        aw_len_i,
  input  logic [SIZE_W-1:0]       aw_size_i,
  output logic [NCNT-1:0]         match_o,
  output logic [NCNT*INC_W-1:0]   incr_o
);
  logic [REG_W-1:0]      shared_cmp;
  logic [NCNT*REG_W-1:0] cnt_cmp;
  logic [NCNT*SEL_W-1:0] cnt_sel;
  logic [INC_W-1:0]      rd_bytes, wr_bytes;
  logic                  rd_hs, wr_hs;

  assign rd_hs = ar_valid_i && ar_ready_i;
  assign wr_hs = aw_valid_i && aw_ready_i;

  afl_cfg_regs #(.NCNT(NCNT), .ADDR_W(ADDR_W), .REG_W(REG_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i),
    .addr_i   (cfg_addr_i),
    .wdata_i  (cfg_wdata_i),
    .shared_o (shared_cmp),
    .cmp_o    (cnt_cmp),
    .sel_o    (cnt_sel)
  );

  afl_burst_bytes #(.LEN_W(LEN_W), .SIZE_W(SIZE_W), .INC_W(INC_W)) u_rd_bytes (
    .len_i (ar_len_i), .size_i (ar_size_i), .bytes_o (rd_bytes)
  );
  afl_burst_bytes #(.LEN_W(LEN_W), .SIZE_W(SIZE_W), .INC_W(INC_W)) u_wr_bytes (
    .len_i (aw_len_i), .size_i (aw_size_i), .bytes_o (wr_bytes)
  );

  for (genvar k = 0; k < NCNT; k++) begin : g_lane
    logic [REG_W-1:0] cmp_k;
    assign cmp_k = per_cnt_i ? cnt_cmp[k*REG_W +: REG_W] : shared_cmp;

    afl_lane #(.ID_W(ID_W), .INC_W(INC_W)) u_lane (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .evt_i       (evt_sel_i[k*EVT_W +: EVT_W]),
      .cmp_i       (cmp_k),
      .sel_i       (cnt_sel[k*SEL_W +: SEL_W]),
      .per_cnt_i   (per_cnt_i),
      .byte_mode_i (byte_mode_i),
      .rd_hs_i     (rd_hs),
      .rd_id_i     (ar_id_i),
      .rd_port_i   (ar_port_i),
      .rd_bytes_i  (rd_bytes),
      .wr_hs_i     (wr_hs),
      .wr_id_i     (aw_id_i),
      .wr_port_i   (aw_port_i),
      .wr_bytes_i  (wr_bytes),
      .match_o     (match_o[k]),
      .incr_o      (incr_o[k*INC_W +: INC_W])
    );
  end
endmodule

// File: rtl/afl_chk.sv
module afl_chk
  import afl_pkg::*;
#(
  parameter int NCNT  = 3,
  parameter int INC_W = 16
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  byte_mode_i,
  input logic [NCNT*EVT_W-1:0] evt_sel_i,
  input logic                  ar_valid_i,
  input logic                  ar_ready_i,
  input logic                  aw_valid_i,
  input logic                  aw_ready_i,
  input logic [NCNT-1:0]       match_o,
  input logic [NCNT*INC_W-1:0] incr_o
);
  logic idle;
  assign idle = !(ar_valid_i && ar_ready_i) && !(aw_valid_i && aw_ready_i);

  for (genvar k = 0; k < NCNT; k++) begin : g_chk
    logic [EVT_W-1:0] evt_k;
    logic [INC_W-1:0] inc_k;
    assign evt_k = evt_sel_i[k*EVT_W +: EVT_W];
    assign inc_k = incr_o[k*INC_W +: INC_W];

    AST_IDLE_NO_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      idle |=> !match_o[k]); // R4
    AST_OTHER_EVT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (evt_k != EVT_RD_MATCH && evt_k != EVT_WR_MATCH) |=> !match_o[k]); // R3
    AST_INCR_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !match_o[k] |-> inc_k == '0); // R10
    AST_INCR_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      match_o[k] |-> inc_k != '0); // R8
    AST_COUNT_UNIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !byte_mode_i |=> (!match_o[k] || inc_k == INC_W'(1))); // R8
  end
endmodule

bind axi_id_filter afl_chk #(.NCNT(NCNT), .INC_W(INC_W)) u_afl_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .byte_mode_i (byte_mode_i),
  .evt_sel_i   (evt_sel_i),
  .ar_valid_i  (ar_valid_i),
  .ar_ready_i  (ar_ready_i),
  .aw_valid_i  (aw_valid_i),
  .aw_ready_i  (aw_ready_i),
  .match_o     (match_o),
  .incr_o      (incr_o)
);

// File: tb/tb_axi_id_filter.sv
`timescale 1ns/1ps
module tb_axi_id_filter;
  localparam int NCNT = 3;
  localparam int INC_W = 16;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic cfg_we_i = 1'b0;
  logic [7:0] cfg_addr_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic per_cnt_i = 1'b0, byte_mode_i = 1'b0;
  logic [NCNT*8-1:0] evt_sel_i = '0;
  logic ar_valid_i = 0, ar_ready_i = 0, aw_valid_i = 0, aw_ready_i = 0;
  logic [15:0] ar_id_i = '0, aw_id_i = '0;
  logic [2:0] ar_port_i = '0, aw_port_i = '0, ar_size_i = '0, aw_size_i = '0;
  logic [7:0] ar_len_i = '0, aw_len_i = '0;
  logic [NCNT-1:0] match_o;
  logic [NCNT*INC_W-1:0] incr_o;

  axi_id_filter dut (.*);

  always #10 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] m_shared;
  logic [31:0] m_cmp [NCNT];
  logic [31:0] m_sel [NCNT];
  logic [31:0] rng = 32'h1ACE_B00C;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish (actual hung, expected done)");
      done = 1;
      summary();
    end
  end

  function automatic logic [31:0] next_rng(input logic [31:0] r);
    logic [31:0] x = r;
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    cfg_we_i = 1; cfg_addr_i = a; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 0;
    if (a == 8'h30) m_shared = d;
    for (int k = 0; k < NCNT; k++) begin
      if (a == 8'(8'h54 + 16*k)) m_cmp[k] = d;
      if (a == 8'(8'h50 + 16*k)) m_sel[k] = {20'h0, d[11:0]};
    end
  endtask

  task automatic calc(input int k, output logic eh, output logic [15:0] ei);
    logic [31:0] c, s;
    logic [7:0] ev;
    logic hs, idok, pok;
    logic [7:0] ln;
    logic [2:0] sz;
    c  = per_cnt_i ? m_cmp[k] : m_shared;
    s  = m_sel[k];
    ev = evt_sel_i[k*8 +: 8];
    hs = 0; idok = 0; pok = 0; ln = 0; sz = 0;
    if (ev == 8'h41) begin
      hs   = ar_valid_i & ar_ready_i;
      idok = ((ar_id_i ^ c[15:0]) & ~c[31:16]) == 16'h0;
      pok  = !per_cnt_i || s[3] || ar_port_i == s[2:0];
      ln = ar_len_i; sz = ar_size_i;
    end else if (ev == 8'h42) begin
      hs   = aw_valid_i & aw_ready_i;
      idok = ((aw_id_i ^ c[15:0]) & ~c[31:16]) == 16'h0;
      pok  = !per_cnt_i || s[11] || aw_port_i == s[10:8];
      ln = aw_len_i; sz = aw_size_i;
    end
    eh = hs && idok && pok;
    ei = !eh ? 16'h0 : (byte_mode_i ? 16'((32'(ln) + 1) << sz) : 16'h1);
  endtask

  // drive one cycle of address-channel activity; check the registered result
  task automatic txn(input string tag);
    logic eh [NCNT];
    logic [15:0] ei [NCNT];
    for (int k = 0; k < NCNT; k++) calc(k, eh[k], ei[k]);
    @(negedge clk_i);
    for (int k = 0; k < NCNT; k++) begin
      n_chk++;
      if (match_o[k] !== eh[k] || incr_o[k*INC_W +: INC_W] !== ei[k]) begin
        n_fail++;
        $display("FAIL %s lane %0d: actual match=%b incr=%0d, expected match=%b incr=%0d",
                 tag, k, match_o[k], incr_o[k*INC_W +: INC_W], eh[k], ei[k]);
      end
    end
    ar_valid_i = 0; aw_valid_i = 0;
  endtask

  task automatic rand_drive(input int m);
    logic [15:0] pick [4];
    pick[0] = m_cmp[0][15:0]; pick[1] = m_cmp[1][15:0];
    pick[2] = m_cmp[2][15:0]; pick[3] = m_shared[15:0];
    @(negedge clk_i);
    rng = next_rng(rng);
    ar_id_i = pick[rng[9:8]] ^ {10'h0, rng[15:10]};
    ar_port_i = rng[18:16];
    ar_valid_i = rng[20] | rng[22]; ar_ready_i = rng[21] | rng[23];
    ar_len_i = rng[31:24]; ar_size_i = rng[2:0];
    rng = next_rng(rng);
    aw_id_i = pick[rng[9:8]] ^ {10'h0, rng[15:10]};
    aw_port_i = rng[18:16];
    aw_valid_i = rng[20] | rng[22]; aw_ready_i = rng[21] | rng[23];
    aw_len_i = rng[31:24]; aw_size_i = rng[2:0];
    if (m < 0) begin ar_valid_i = 0; aw_valid_i = 0; end
  endtask

  initial begin
    m_shared = '0;
    for (int k = 0; k < NCNT; k++) begin m_cmp[k] = '0; m_sel[k] = '0; end
    repeat (3) @(negedge clk_i);
    // R1: outputs idle under reset and after release
    n_chk++;
    if (match_o !== '0 || incr_o !== '0) begin
      n_fail++;
      $display("FAIL R1 reset: actual match=%b incr=%h, expected 0", match_o, incr_o);
    end
    rst_ni = 1;
    @(negedge clk_i);
    // R1: zeroed shared register matches only ID 0 exactly
    evt_sel_i = {8'h42, 8'h41, 8'h41};
    ar_id_i = 16'h0000; ar_valid_i = 1; ar_ready_i = 1; ar_len_i = 8'd3; ar_size_i = 3'd2;
    aw_id_i = 16'h0001; aw_valid_i = 1; aw_ready_i = 1;
    txn("R1 reset config");

    for (int m = 0; m < 4; m++) begin
      per_cnt_i   = m[1];
      byte_mode_i = m[0];
      evt_sel_i = {(m == 0) ? 8'h42 : (m == 1) ? 8'h10 : (m == 2) ? 8'h41 : 8'h42,
                   8'h42, 8'h41};
      wr_reg(8'h30, {~16'hFFFC, 16'h0F00 + 16'(m)});
      wr_reg(8'h54, {~16'hFFF0, 16'h1234});
      wr_reg(8'h64, {~16'hFF00, 16'hABCD});
      wr_reg(8'h74, {~16'hFFFF, 16'h0055 + 16'(m)});
      wr_reg(8'h50, {20'h0, 4'b1101, 4'b0000, 4'b0010});
      wr_reg(8'h60, {20'h0, 4'b0011, 4'b0000, 4'b1110});
      wr_reg(8'h70, {20'h0, 4'b0000, 4'b0000, 4'b0111});
      // R9: stray writes between and beside the registers
      @(negedge clk_i);
      cfg_we_i = 1; cfg_wdata_i = 32'hFFFF_FFFF;
      cfg_addr_i = 8'h58; @(negedge clk_i);
      cfg_addr_i = 8'h34; @(negedge clk_i);
      cfg_addr_i = 8'h51; @(negedge clk_i);
      cfg_addr_i = 8'h2C; @(negedge clk_i);
      cfg_we_i = 0;
      // R9: a configured read still matches after the stray writes
      ar_id_i = per_cnt_i ? 16'h1234 : m_shared[15:0];
      ar_port_i = 3'd2; ar_valid_i = 1; ar_ready_i = 1; ar_len_i = 0; ar_size_i = 0;
      aw_valid_i = 0;
      txn("R9 stray write");
      for (int i = 0; i < 300; i++) begin
        rand_drive((i % 37 == 0) ? -1 : m);
        if (per_cnt_i) txn("R2 R3 R4 R6 R7 R8 R10");
        else           txn("R2 R3 R4 R5 R8 R10");
      end
    end
    done = 1;
    summary();
  end
endmodule